// File: doc/BRIEF.md
# Interrupt group register bank

This block holds the four 32-bit registers of one interrupt group. Single-cycle event pulses arrive on a 32-bit input. Each pulse lands in a pending register unless its mask bit is set. A masked pulse is thrown away, so it does not appear later when the mask is cleared. Software clears pending bits by writing ones to them.

The group drives a 32-bit summary equal to pending AND enable, and an upstream aggregator consumes it. A one-cycle re-evaluate strobe follows every register change that can move the summary, so the aggregator knows to look again. This includes clearing writes, which can let a parent indication drop.

Register access is a plain port. A write enable, a byte offset and write data update the bank on the clock edge. Read data is a combinational function of the offset. The offsets are status 0x0, mask 0x4, pending 0x8 and enable 0xC.

Top module: `irq_group_bank`

## Requirements
- R1: After reset the mask, pending and enable registers read zero, `summary_o` is zero and `reeval_o` is low.
- R2: An event pulse on bit n sets pending bit n at the next clock edge when mask bit n is zero at that edge.
- R3: An event on a bit whose mask bit is one is discarded: pending bit n stays clear, including after the mask bit is later cleared.
- R4: A write to offset 0x8 clears every pending bit written as one and leaves bits written as zero unchanged.
- R5: If an accepted event and a clearing write hit the same pending bit in the same cycle, the bit ends set.
- R6: A write to offset 0x4 (mask) or 0xC (enable) replaces the whole 32-bit value, which reads back unchanged.
- R7: `summary_o` always equals pending AND enable as last written.
- R8: `reeval_o` is high for exactly the one cycle after a cycle holding a write to offset 0x4, 0x8 or 0xC, or at least one accepted event. It is low otherwise.
- R9: Offset 0x0 reads the live `evt_i` value. A write to it changes no register and raises no strobe.
- R10: Offsets other than 0x0, 0x4, 0x8 and 0xC read zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the register port |
| addr_i | input | ADDR_W | Byte offset of the accessed register |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for `addr_i` (combinational) |
| evt_i | input | DW | Event pulses, one per bit |
| summary_o | output | DW | Pending AND enable, to the upstream level |
| reeval_o | output | 1 | One-cycle request for upstream re-evaluation |

## Verification
Directed sequences cover the cases that random stimulus reaches rarely:
- A pulse that arrives while masked and is then unmasked, which separates dropping an event from deferring it.
- A clear and an event on the same bit in the same cycle, which exposes clear-over-set priority.
- Writes to the status offset and to undecoded offsets, which separate real decode from partial address matching.

Random stimulus then mixes sparse event vectors with writes and reads at both decoded and undecoded offsets. Summary, strobe and read data are compared each cycle against a bench model. This catches wrong mask timing, a summary gated by the mask instead of by the enable, and strobes raised by masked-only events.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam logic [3:0] OFF_STATUS = 4'h0;
  localparam logic [3:0] OFF_MASK   = 4'h4;
  localparam logic [3:0] OFF_PEND   = 4'h8;
  localparam logic [3:0] OFF_EN     = 4'hC;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_MASK,
    SEL_PEND,
    SEL_EN
  } reg_sel_e;
endpackage

// File: rtl/irq_bank_decode.sv
module irq_bank_decode
  import irq_bank_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic              wr_mask_o,
  output logic              wr_pend_o,
  output logic              wr_en_o
);
  always_comb begin
    if      (addr_i == ADDR_W'(OFF_STATUS)) sel_o = SEL_STATUS;
    else if (addr_i == ADDR_W'(OFF_MASK))   sel_o = SEL_MASK;
    else if (addr_i == ADDR_W'(OFF_PEND))   sel_o = SEL_PEND;
    else if (addr_i == ADDR_W'(OFF_EN))     sel_o = SEL_EN;
    else                                    sel_o = SEL_NONE;
  end

  assign wr_mask_o = wr_en_i && (sel_o == SEL_MASK);
  assign wr_pend_o = wr_en_i && (sel_o == SEL_PEND);
  assign wr_en_o   = wr_en_i && (sel_o == SEL_EN);
endmodule

// File: rtl/irq_bank_word.sv
module irq_bank_word #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/irq_bank_pending.sv
module irq_bank_pending #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] evt_i,
  input  logic [DW-1:0] mask_i,
  input  logic [DW-1:0] clr_i,
  output logic [DW-1:0] pend_o,
  output logic          accept_o
);
  logic [DW-1:0] hit;

  // events are filtered against the mask at arrival; nothing is held back
  assign hit      = evt_i & ~mask_i;
  assign accept_o = |hit;

  // set dominates clear on the same bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= (pend_o & ~clr_i) | hit;
  end
endmodule

// File: rtl/irq_group_bank.sv
module irq_group_bank
  import irq_bank_pkg::*;
#(
  parameter int DW     = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [DW-1:0]     evt_i,
  output logic [DW-1:0]     summary_o,
  output logic              reeval_o
);
  localparam int NUM_CFG = 2;  // 0: mask, 1: enable

  reg_sel_e      sel;
  logic          wr_mask, wr_pend, wr_enable;
  logic          accept;
  logic [DW-1:0] mask_q, enable_q, pending_q;
  logic [DW-1:0] clr;
  logic [NUM_CFG-1:0] cfg_we;
  logic [DW-1:0] cfg_q [NUM_CFG];

  irq_bank_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .sel_o     (sel),
    .wr_mask_o (wr_mask),
    .wr_pend_o (wr_pend),
    .wr_en_o   (wr_enable)
  );

  assign cfg_we = {wr_enable, wr_mask};

  for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg
    irq_bank_word #(.DW(DW)) u_word (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (cfg_we[k]),
      .d_i    (wdata_i),
      .q_o    (cfg_q[k])
    );
  end

  assign mask_q   = cfg_q[0];
  assign enable_q = cfg_q[1];
  assign clr      = wr_pend ? wdata_i : '0;

  irq_bank_pending #(.DW(DW)) u_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_i),
    .mask_i   (mask_q),
    .clr_i    (clr),
    .pend_o   (pending_q),
    .accept_o (accept)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reeval_o <= 1'b0;
    else         reeval_o <= wr_mask | wr_pend | wr_enable | accept;
  end

  assign summary_o = pending_q & enable_q;

  always_comb begin
    unique case (sel)
      SEL_STATUS: rdata_o = evt_i;
      SEL_MASK:   rdata_o = mask_q;
      SEL_PEND:   rdata_o = pending_q;
      SEL_EN:     rdata_o = enable_q;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_group_bank_chk.sv
module irq_group_bank_chk #(
  parameter int DW     = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic [DW-1:0]     evt_i,
  input logic              reeval_o,
  input logic [DW-1:0]     mask_q,
  input logic [DW-1:0]     enable_q,
  input logic [DW-1:0]     pending_q
);
  logic          wr_m, wr_p, wr_e;
  logic [DW-1:0] acc;
  assign wr_m = wr_en_i && (addr_i == ADDR_W'(4'h4));
  assign wr_p = wr_en_i && (addr_i == ADDR_W'(4'h8));
  assign wr_e = wr_en_i && (addr_i == ADDR_W'(4'hC));
  assign acc  = evt_i & ~mask_q;

  // R2 / R5: accepted events are set next cycle, even against a clear
  a_r5_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc != '0) |=> ((pending_q & $past(acc)) == $past(acc)));

  // R3: no pending bit rises without an accepted event
  a_r3_no_masked_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pending_q & ~$past(pending_q) & ~$past(acc)) == '0));

  // R4: written ones clear unless an event reasserts them
  a_r4_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_p |=> ((pending_q & $past(wdata_i) & ~$past(acc)) == '0));

  a_r6_mask_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_m |=> (mask_q == $past(wdata_i)));

  a_r6_enable_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_e |=> (enable_q == $past(wdata_i)));

  a_r8_strobe_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_m || wr_p || wr_e || (acc != '0)) |=> reeval_o);

  a_r8_strobe_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_m || wr_p || wr_e || (acc != '0)) |=> !reeval_o);
endmodule

bind irq_group_bank irq_group_bank_chk #(.DW(DW), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .evt_i     (evt_i),
  .reeval_o  (reeval_o),
  .mask_q    (mask_q),
  .enable_q  (enable_q),
  .pending_q (pending_q)
);

// File: tb/irq_group_bank_test.sv
`timescale 1ns/1ps
module irq_group_bank_test;
  localparam int DW = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] evt = '0;
  logic [DW-1:0] rdata, summary;
  logic          reeval;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] m_mask = '0, m_pend = '0, m_en = '0;
  logic          m_reev = 1'b0;

  always #10 clk = ~clk;

  irq_group_bank #(.DW(DW), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt),
    .summary_o(summary), .reeval_o(reeval)
  );

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_read(logic [AW-1:0] a, logic [DW-1:0] ev);
    case (a)
      4'h0:    return ev;
      4'h4:    return m_mask;
      4'h8:    return m_pend;
      4'hC:    return m_en;
      default: return '0;
    endcase
  endfunction

  function automatic string read_tag(logic [AW-1:0] a);
    case (a)
      4'h0:       return "R9";
      4'h4, 4'hC: return "R6";
      4'h8:       return "R4";
      default:    return "R10";
    endcase
  endfunction

  // called at a negedge; returns at the following negedge
  task automatic step(bit we, logic [AW-1:0] a, logic [DW-1:0] wd,
                      logic [DW-1:0] ev, string tag);
    logic [DW-1:0] acc, clr;
    bit qual;
    wr_en = we; addr = a; wdata = wd; evt = ev;
    #1;
    chk((tag == "") ? read_tag(a) : tag, rdata, exp_read(a, ev));
    acc  = ev & ~m_mask;
    clr  = (we && a == 4'h8) ? wd : '0;
    qual = we && (a == 4'h4 || a == 4'h8 || a == 4'hC);
    @(posedge clk);
    m_pend = (m_pend & ~clr) | acc;
    if (we && a == 4'h4) m_mask = wd;
    if (we && a == 4'hC) m_en = wd;
    m_reev = qual || (acc != '0);
    @(negedge clk);
    chk("R7", summary, m_pend & m_en);
    chk("R8", {31'b0, reeval}, {31'b0, m_reev});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", summary, '0);
    chk("R1", {31'b0, reeval}, '0);
    step(0, 4'h4, '0, '0, "R1");
    step(0, 4'h8, '0, '0, "R1");
    step(0, 4'hC, '0, '0, "R1");
    // R6 enable replace and readback
    step(1, 4'hC, 32'hFFFF_FFFF, '0, "R6");
    step(0, 4'hC, '0, '0, "R6");
    // R2 unmasked event latches
    step(0, 4'h0, '0, 32'h0000_0008, "R9");
    step(0, 4'h8, '0, '0, "R2");
    chk("R2", rdata, 32'h0000_0008);
    // R3 masked event dropped, not replayed on unmask
    step(1, 4'h4, 32'h0000_0020, '0, "R6");
    step(0, 4'h0, '0, 32'h0000_0020, "R9");
    chk("R3", {31'b0, reeval}, '0);
    step(1, 4'h4, '0, '0, "R6");
    step(0, 4'h8, '0, '0, "R3");
    chk("R3", rdata, 32'h0000_0008);
    // R5 event beats clear on the same bit
    step(1, 4'h8, 32'h0000_0008, 32'h0000_0008, "R4");
    step(0, 4'h8, '0, '0, "R5");
    chk("R5", rdata, 32'h0000_0008);
    // R4 write-one-to-clear, zeros untouched
    step(0, 4'h0, '0, 32'h0000_0101, "R9");
    step(1, 4'h8, 32'h0000_0008, '0, "R4");
    step(0, 4'h8, '0, '0, "R4");
    chk("R4", rdata, 32'h0000_0101);
    // R9 write to status ignored
    step(1, 4'h0, 32'hFFFF_FFFF, '0, "R9");
    chk("R9", {31'b0, reeval}, '0);
    step(0, 4'h4, '0, '0, "R9");
    // R10 undecoded offsets
    step(1, 4'h6, 32'hFFFF_FFFF, '0, "R10");
    chk("R10", {31'b0, reeval}, '0);
    step(0, 4'h5, '0, '0, "R10");
    step(0, 4'h8, '0, '0, "R10");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] ev, wd;
      bit we;
      a  = ($urandom % 4 != 0) ? AW'(($urandom % 4) * 4) : AW'($urandom % 16);
      we = ($urandom % 3 == 0);
      wd = ($urandom % 2) ? $urandom : ($urandom & $urandom & $urandom);
      ev = ($urandom % 2) ? ($urandom & $urandom & $urandom) : '0;
      step(we, a, wd, ev, "");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule